// File: doc/BRIEF.md
# PS/2 Host Channel Controller with Timeout Supervision

This block is the host end of one PS/2 link. It watches the open-drain clock and data lines and assembles frames clocked by the attached device into a receive register. When software writes a byte, it sends that byte to the device. Three hardware watchdogs measure the link's timing: the gap between clock falls, the wait for the device to start clocking a host request, and the length of a frame from start bit to parity bit. When any of them expires, the frame is abandoned, both lines are let go, and a hold window follows before the link is used again.

When the enable control bit is cleared, the controller steps aside and software drives the lines directly. Status reads then return the live pin levels, and every device-driven falling clock edge latches an interrupt. Leaving normal mode is refused while a timeout flag is pending, while the hold window runs, or while unread receive data is waiting.

All time limits are whole microseconds. A prescaler divides the system clock by `TICK_DIV` to produce the microsecond tick. Registers: address 0 is data, address 1 is control, address 2 is status.

Top module: `ps2_host_chan`

## Requirements
- R1: After reset: control reads 0x06 (enable=bit0 clear, clock-release bit1 and data-release bit2 set); status reads 0xC0 with both lines idle high; neither line is pulled low; `irq` is low.
- R2: With enable set, a frame of start 0, eight data bits LSB first, parity and stop bit 1, sampled on falling clock edges, is stored in the data register. It also sets ready (status bit0) and raises `irq`. Reading address 0 clears ready.
- R3: If the received parity bit does not make the count of ones over data plus parity odd, status bit2 is set. Ready is still set. Writing 1 to bit2 clears it.
- R4: Status bit1 (receive busy) is 1 while a frame is being received and 0 once it has ended.
- R5: Writing address 0 while enabled and idle starts a send. The clock is held low first, then data is pulled low and the clock is released. After each device falling edge, the next bit of data (LSB first), odd parity and then stop 1 is presented. After the eleventh fall the channel is idle with both lines released.
- R6: During a frame, if consecutive clock falls are more than `BIT_US` apart, the frame is dropped (ready stays 0), both lines are released, and timeout flag status bit4 is set. Writing 1 to bit4 clears it.
- R7: If no clock fall arrives within `START_US` after a send request, status bit3 and bit4 are set and the data line is released. Both bits are cleared by writing 1.
- R8: If more than `FRAME_US` passes from the start-bit fall before the parity bit is taken, the frame is dropped and status bit4 is set.
- R9: After any timeout, a hold window of `HOLD_US` follows. During it, both lines stay released and a write clearing enable is refused, even once the flag has been cleared.
- R10: With enable clear, control bit1 and bit2 drive the clock and data lines (0 pulls low, 1 releases). Status bit6 shows the live clock level and bit7 the live data level.
- R11: With enable clear, a clock fall caused by the device sets status bit5 and raises `irq`. A fall caused by the host's own clock drive does not. Writing 1 to bit5 clears it.
- R12: A write clearing enable is refused while ready is set or while timeout flag bit4 is set. Otherwise it is accepted.
- R13: The request's clock-low phase lasts at least `INHIBIT_US` ticks of `TICK_DIV` system clocks each, and no more than three ticks longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of address 0 clears ready) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ps2_clk_in | input | 1 | Level of the clock line |
| ps2_dat_in | input | 1 | Level of the data line |
| ps2_clk_low | output | 1 | 1 pulls the clock line low |
| ps2_dat_low | output | 1 | 1 pulls the data line low |
| irq | output | 1 | Ready, timeout flag or bit-bang edge pending |

## Verification
The bench stretches the device's clock period until a frame overruns its length limit, even though every single bit gap stays legal. A design that checked only the per-bit gap would wrongly deliver that frame as ready. It stops a frame after two bits, then clears the flag and tries to leave normal mode inside the hold window. A design without the hold would accept that write. It drives the clock low from software in bit-bang mode to catch a design that treats its own drive as a device edge. It also holds data unread and tries to disable, to catch a design that drops received data without warning.

// File: rtl/ps2_chan_pkg.sv
package ps2_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_INHIB,
        ST_REQ,
        ST_TXB,
        ST_HOLD
    } chan_st_e;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int C_EN   = 0;
    localparam int C_CLKR = 1;
    localparam int C_DATR = 2;

    localparam int S_PERR = 2;
    localparam int S_STO  = 3;
    localparam int S_TO   = 4;
    localparam int S_EDGE = 5;

    localparam int NTMR  = 3;
    localparam int T_GEN = 0;
    localparam int T_BIT = 1;
    localparam int T_FRM = 2;

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/ps2_tick_gen.sv
module ps2_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == LAST);
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ps2_pin_sync.sv
module ps2_pin_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic         clk_fell
);
    logic [N-1:0] meta;
    logic         prev;

    for (genvar gi = 0; gi < N; gi++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[gi] <= 1'b1;
                lvl[gi]  <= 1'b1;
            end else begin
                meta[gi] <= pin[gi];
                lvl[gi]  <= meta[gi];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= lvl[0];
    end

    assign clk_fell = prev & ~lvl[0];
endmodule

// File: rtl/ps2_us_timer.sv
module ps2_us_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)              cnt <= '0;
        else if (tick && cnt != '1)  cnt <= cnt + 1'b1;
    end

    p_count_step_r13: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && cnt != '1) |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/ps2_host_chan.sv
module ps2_host_chan
    import ps2_chan_pkg::*;
#(
    parameter int TICK_DIV   = 125,
    parameter int BIT_US     = 300,
    parameter int START_US   = 25000,
    parameter int FRAME_US   = 2000,
    parameter int HOLD_US    = 300,
    parameter int INHIBIT_US = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_low,
    output logic       ps2_dat_low,
    output logic       irq
);
    localparam int TW = $clog2(START_US + FRAME_US + BIT_US + HOLD_US + INHIBIT_US + 2);
    localparam logic [TW-1:0] LIM_BIT   = TW'(BIT_US);
    localparam logic [TW-1:0] LIM_START = TW'(START_US);
    localparam logic [TW-1:0] LIM_FRM   = TW'(FRAME_US);
    localparam logic [TW-1:0] LIM_HOLD  = TW'(HOLD_US);
    localparam logic [TW-1:0] LIM_INH   = TW'(INHIBIT_US);

    logic          tick, fell;
    logic [1:0]    lvl;
    logic [TW-1:0] tmr [NTMR];
    logic [NTMR-1:0] tclr;

    chan_st_e   state;
    logic [3:0] cnt;
    logic [7:0] rsh, rx_data;
    logic [9:0] txsh;
    logic       rpar, rdy, perr, start_to, to_flag, bb_edge;
    logic       f_clk_low, f_dat_low, g_clr;
    logic       en, sw_clk_rel, sw_dat_rel;

    ps2_tick_gen #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    ps2_pin_sync #(.N(2)) u_sync (
        .clk(clk), .rst(rst), .pin({ps2_dat_in, ps2_clk_in}),
        .lvl(lvl), .clk_fell(fell));

    for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
        ps2_us_timer #(.W(TW)) u_tmr (
            .clk(clk), .rst(rst), .tick(tick), .clr(tclr[gi]), .cnt(tmr[gi]));
    end

    // Timer supervision
    logic bit_act, frm_act, to_hit, gen_ok;
    assign bit_act = (state == ST_RX) || (state == ST_TXB);
    assign frm_act = (state == ST_RX && cnt <= 4'd8) || (state == ST_TXB && cnt <= 4'd9);
    assign gen_ok  = !g_clr;
    assign tclr[T_GEN] = g_clr;
    assign tclr[T_BIT] = fell || !bit_act;
    assign tclr[T_FRM] = !bit_act;
    assign to_hit = (bit_act && tmr[T_BIT] > LIM_BIT) ||
                    (frm_act && tmr[T_FRM] > LIM_FRM) ||
                    (state == ST_REQ && gen_ok && tmr[T_GEN] > LIM_START);

    // Register decode
    logic wr_tx, wr_ctrl, wr_stat, rd_rx, dis_block, bb_fall;
    assign wr_tx     = reg_wr && reg_addr == A_DATA && en && state == ST_IDLE;
    assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
    assign wr_stat   = reg_wr && reg_addr == A_STAT;
    assign rd_rx     = reg_rd && reg_addr == A_DATA;
    assign dis_block = to_flag || state == ST_HOLD || rdy;
    assign bb_fall   = fell && sw_clk_rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            en         <= 1'b0;
            sw_clk_rel <= 1'b1;
            sw_dat_rel <= 1'b1;
        end else if (wr_ctrl) begin
            sw_clk_rel <= reg_wdata[C_CLKR];
            sw_dat_rel <= reg_wdata[C_DATR];
            en         <= reg_wdata[C_EN] || (en && dis_block);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  cnt <= '0;  rsh <= '0;  rx_data <= '0;
            txsh <= '0;  rpar <= 1'b0;  rdy <= 1'b0;  perr <= 1'b0;
            start_to <= 1'b0;  to_flag <= 1'b0;  bb_edge <= 1'b0;
            f_clk_low <= 1'b0;  f_dat_low <= 1'b0;  g_clr <= 1'b0;
        end else begin
            g_clr <= 1'b0;
            if (wr_stat) begin
                if (reg_wdata[S_PERR]) perr     <= 1'b0;
                if (reg_wdata[S_STO])  start_to <= 1'b0;
                if (reg_wdata[S_TO])   to_flag  <= 1'b0;
                if (reg_wdata[S_EDGE]) bb_edge  <= 1'b0;
            end
            if (rd_rx) rdy <= 1'b0;
            if (!en && bb_fall) bb_edge <= 1'b1;

            if (!en) begin
                state <= ST_IDLE;  f_clk_low <= 1'b0;  f_dat_low <= 1'b0;
            end else if (to_hit) begin
                state     <= ST_HOLD;
                to_flag   <= 1'b1;
                start_to  <= start_to || (state == ST_REQ);
                f_clk_low <= 1'b0;
                f_dat_low <= 1'b0;
                g_clr     <= 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (wr_tx) begin
                            txsh      <= {1'b1, odd_par(reg_wdata), reg_wdata};
                            f_clk_low <= 1'b1;
                            g_clr     <= 1'b1;
                            state     <= ST_INHIB;
                        end else if (fell && !lvl[1]) begin
                            cnt   <= '0;
                            state <= ST_RX;
                        end
                    end
                    ST_RX: if (fell) begin
                        if (cnt < 4'd8)       rsh  <= {lvl[1], rsh[7:1]};
                        else if (cnt == 4'd8) rpar <= lvl[1];
                        else begin
                            rx_data <= rsh;
                            rdy     <= 1'b1;
                            perr    <= ~(^{rsh, rpar});
                            state   <= ST_IDLE;
                        end
                        cnt <= cnt + 1'b1;
                    end
                    ST_INHIB: if (gen_ok && tmr[T_GEN] > LIM_INH) begin
                        f_clk_low <= 1'b0;
                        f_dat_low <= 1'b1;
                        g_clr     <= 1'b1;
                        state     <= ST_REQ;
                    end
                    ST_REQ: if (fell) begin
                        f_dat_low <= ~txsh[0];
                        cnt       <= 4'd1;
                        state     <= ST_TXB;
                    end
                    ST_TXB: if (fell) begin
                        if (cnt == 4'd10) begin
                            f_dat_low <= 1'b0;
                            state     <= ST_IDLE;
                        end else begin
                            f_dat_low <= ~txsh[cnt];
                            cnt       <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: if (gen_ok && tmr[T_GEN] > LIM_HOLD) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign ps2_clk_low = en ? f_clk_low : ~sw_clk_rel;
    assign ps2_dat_low = en ? f_dat_low : ~sw_dat_rel;
    assign irq         = rdy | to_flag | bb_edge;

    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = rx_data;
            A_CTRL:  reg_rdata = {5'b0, sw_dat_rel, sw_clk_rel, en};
            A_STAT:  reg_rdata = {lvl[1], lvl[0], bb_edge, to_flag, start_to,
                                  perr, state == ST_RX, rdy};
            default: reg_rdata = 8'h00;
        endcase
    end

    p_hold_release_r9: assert property (@(posedge clk) disable iff (rst)
        state == ST_HOLD |-> !ps2_clk_low && !ps2_dat_low);
    p_rdy_keeps_en_r12: assert property (@(posedge clk) disable iff (rst)
        (en && rdy) |=> en);
    p_rdy_from_rx_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(state) == ST_RX);
    p_edge_only_bb_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(bb_edge) |-> !$past(en));
    p_start_to_from_req_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(start_to) |-> $past(state) == ST_REQ);
endmodule

// File: tb/sim_ps2_host_chan.sv
`timescale 1ns/1ps
module sim_ps2_host_chan;
    localparam int DIV = 4;
    localparam int INH = 10;
    localparam int HP  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic ps2_clk_low, ps2_dat_low, irq;
    logic dev_clk_low = 1'b0, dev_dat_low = 1'b0;
    logic clk_line, dat_line;
    int   n_cmp = 0, n_err = 0;
    bit   done = 1'b0;

    assign clk_line = ~(ps2_clk_low | dev_clk_low);
    assign dat_line = ~(ps2_dat_low | dev_dat_low);

    always #4 clk = ~clk;

    ps2_host_chan #(.TICK_DIV(DIV), .BIT_US(20), .START_US(300), .FRAME_US(150),
                    .HOLD_US(40), .INHIBIT_US(INH)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ps2_clk_in(clk_line),
        .ps2_dat_in(dat_line), .ps2_clk_low(ps2_clk_low), .ps2_dat_low(ps2_dat_low),
        .irq(irq));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic dev_bits(input logic [10:0] fr, input int nb, input int h);
        for (int i = 0; i < nb; i++) begin
            dev_dat_low = ~fr[i];
            wait_cyc(h);
            dev_clk_low = 1'b1;
            wait_cyc(h);
            dev_clk_low = 1'b0;
        end
    endtask

    task automatic dev_send(input logic [7:0] d, input logic good, input int h);
        logic [10:0] fr;
        fr = {1'b1, good ? ~(^d) : ^d, d, 1'b0};
        dev_bits(fr, 11, h);
        dev_dat_low = 1'b0;
        wait_cyc(h);
    endtask

    task automatic t_reset_and_bitbang();
        logic [7:0] v;
        rd(2'd1, v); chk("R1 ctrl", v, 8'h06);
        rd(2'd2, v); chk("R1 status", v, 8'hC0);
        chk("R1 lines", {ps2_clk_low, ps2_dat_low, irq}, 3'b000);
        wr(2'd1, 8'h04); wait_cyc(5);
        chk("R10 clk drive", ps2_clk_low, 1'b1);
        rd(2'd2, v); chk("R10/R11 own fall no edge", v, 8'h80);
        chk("R11 irq quiet", irq, 1'b0);
        wr(2'd1, 8'h02); wait_cyc(5);
        chk("R10 dat drive", {ps2_clk_low, ps2_dat_low}, 2'b01);
        rd(2'd2, v); chk("R10 dat level", v, 8'h40);
        wr(2'd1, 8'h06); wait_cyc(5);
        dev_clk_low = 1'b1; wait_cyc(5);
        rd(2'd2, v); chk("R11 device fall", v, 8'hA0);
        chk("R11 irq", irq, 1'b1);
        dev_clk_low = 1'b0; wait_cyc(5);
        wr(2'd2, 8'h20); wait_cyc(2);
        rd(2'd2, v); chk("R11 w1c", v, 8'hC0);
        chk("R11 irq clear", irq, 1'b0);
        wr(2'd1, 8'h07);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        dev_send(8'hC3, 1'b1, HP);
        rd(2'd2, v); chk("R2 ready", v, 8'hC1);
        chk("R2 irq", irq, 1'b1);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R12 refuse ready", v, 8'h07);
        rd(2'd0, v); chk("R2 data", v, 8'hC3);
        rd(2'd2, v); chk("R2 ready clear", v, 8'hC0);
        dev_send(8'h00, 1'b1, HP);
        rd(2'd0, v); chk("R2 data 00", v, 8'h00);
        dev_send(8'hFF, 1'b1, HP);
        rd(2'd0, v); chk("R2 data FF", v, 8'hFF);
        dev_send(8'h5A, 1'b0, HP);
        rd(2'd2, v); chk("R3 parity err", v, 8'hC5);
        rd(2'd0, v); chk("R3 data kept", v, 8'h5A);
        wr(2'd2, 8'h04);
        rd(2'd2, v); chk("R3 w1c", v, 8'hC0);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        fork
            dev_send(8'h81, 1'b1, HP);
            begin wait_cyc(150); rd(2'd2, v); end
        join
        chk("R4 busy mid", v[1], 1'b1);
        rd(2'd2, v); chk("R4 busy end", v[1:0], 2'b01);
        rd(2'd0, v); chk("R4 data", v, 8'h81);
    endtask

    task automatic t_transmit();
        int n;
        logic [9:0] got;
        wr(2'd0, 8'hA5);
        n = 0;
        while (ps2_clk_low && n < 500) begin n++; @(negedge clk); end
        chk("R13 inhibit length", (n >= INH*DIV && n <= (INH+3)*DIV), 1'b1);
        chk("R5 request", {ps2_clk_low, ps2_dat_low}, 2'b01);
        for (int k = 1; k <= 11; k++) begin
            wait_cyc(HP);
            if (k == 11) dev_dat_low = 1'b1;
            dev_clk_low = 1'b1;
            wait_cyc(HP);
            if (k <= 10) got[k-1] = dat_line;
            dev_clk_low = 1'b0;
        end
        wait_cyc(3);
        dev_dat_low = 1'b0;
        wait_cyc(10);
        chk("R5 byte", got[7:0], 8'hA5);
        chk("R5 parity/stop", got[9:8], 2'b11);
        chk("R5 released", {ps2_clk_low, ps2_dat_low}, 2'b00);
    endtask

    task automatic t_bit_timeout();
        logic [7:0] v;
        dev_bits({1'b1, 1'b1, 8'hFF, 1'b0}, 3, HP);
        dev_dat_low = 1'b0;
        wait_cyc(120);
        rd(2'd2, v); chk("R6 bit timeout", v, 8'hD0);
        chk("R6 released", {ps2_clk_low, ps2_dat_low}, 2'b00);
        wr(2'd2, 8'h10);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R9 hold refuses", v, 8'h07);
        rd(2'd2, v); chk("R9 flag cleared", v, 8'hC0);
        wait_cyc(220);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R12 accepted", v, 8'h06);
        wr(2'd1, 8'h07);
    endtask

    task automatic t_frame_timeout();
        logic [7:0] v;
        dev_send(8'h3C, 1'b1, 36);
        rd(2'd2, v); chk("R8 frame timeout", v, 8'hD0);
        wait_cyc(200);
        wr(2'd2, 8'h10);
        rd(2'd2, v); chk("R8 clear", v, 8'hC0);
    endtask

    task automatic t_start_timeout();
        logic [7:0] v;
        wr(2'd0, 8'h3C);
        wait_cyc(1400);
        rd(2'd2, v); chk("R7 start timeout", v, 8'hD8);
        chk("R7 released", {ps2_clk_low, ps2_dat_low}, 2'b00);
        wait_cyc(300);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R12 refuse flag", v, 8'h07);
        wr(2'd2, 8'h18);
        rd(2'd2, v); chk("R7 w1c", v, 8'hC0);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R12 accepted after clear", v, 8'h06);
        wr(2'd1, 8'h07);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset_and_bitbang();
        wait_cyc(10);
        t_receive();
        t_busy();
        t_transmit();
        t_bit_timeout();
        t_frame_timeout();
        t_start_timeout();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule